// File: doc/BRIEF.md
# Multi-Width Mask Register Left Shifter

This block is one execution unit for predicate masks. It accepts a 64-bit source mask, an 8-bit unsigned shift count, the opcode byte, the W bit and the ModRM byte of a decoded instruction. From the opcode byte and the W bit it picks one of four operand widths: 8, 16, 32 or 64 bits. It shifts the low bits of the source left by the count. It then returns a 64-bit result with every bit at or above the chosen width cleared.

A count larger than the highest bit index of the chosen width gives an all-zero result. An encoding that is not valid gives an all-zero result and raises an illegal flag. An encoding is not valid when the opcode is not one of the two shift opcodes, or when it is not the register-to-register form. The unit has no effect on status flags.

Inputs are taken on a valid strobe. The result, the illegal flag and the valid output come out of a single register stage. The shifter is a six-stage logarithmic network. A separate compare on the full 8-bit count catches every count that is out of range.

Top module: `mask_lshift_unit`

## Requirements
- R1: Opcode byte 0x32 selects the 8-bit form when W=0 and the 16-bit form when W=1.
- R2: Opcode byte 0x33 selects the 32-bit form when W=0 and the 64-bit form when W=1.
- R3: When the count is at most width-1, result bits [width-1:0] equal source bits [width-1:0] shifted left by the count, with zeros filling from bit 0.
- R4: The count is the full 8-bit immediate, read as unsigned. Any count of width or more (8, 16, 32 or 64, up to 255) gives a result of zero.
- R5: Result bits at and above the selected width are always zero, whatever the upper source bits hold.
- R6: ModRM bits [7:6] other than 2'b11 set the illegal output to 1 and force the result to zero.
- R7: An opcode byte other than 0x32 or 0x33 sets the illegal output to 1 and forces the result to zero. A legal encoding gives illegal = 0.
- R8: The result, the illegal flag and validOut appear exactly one clock after validIn is sampled high. validOut is low in cycles that follow validIn low, and the result and the illegal flag hold their last values in those cycles.
- R9: A synchronous active-high reset clears validOut, the result and the illegal flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Capture strobe for the operands |
| srcMask | input | 64 | Source mask |
| immCount | input | 8 | Unsigned shift count |
| opByte | input | 8 | Opcode byte (0x32 or 0x33) |
| wBit | input | 1 | W bit that selects the width |
| modrmByte | input | 8 | ModRM byte; bits [7:6] must be 11b |
| validOut | output | 1 | Result valid, one clock after validIn |
| dstMask | output | 64 | Zero-extended shifted mask |
| illegalOut | output | 1 | Illegal encoding flag |

## Verification
The test runs each of the four widths over every count from 0 to 255. It uses a source of all ones and a sparse, irregular pattern. The all-ones source shows whether the upper bits are cleared and where the fill starts. The sparse pattern exposes a wrong stage in the shift network. The boundary counts width-1 and width, and the count 255, tell the overflow compare apart from a compare on the truncated count. Encodings that differ only in a ModRM field or in the opcode byte show that the illegal path zeroes the result. An idle stretch between valid operations shows that the result register holds its value.

// File: rtl/mskshl_pkg.sv
package mskshl_pkg;
  localparam int DATA_W  = 64;
  localparam int CNT_W   = 8;
  localparam int MIN_W   = 8;
  localparam int NUM_WID = 4;
  localparam int SHAMT_W = $clog2(DATA_W);

  localparam logic [7:0] OP_NARROW = 8'h32;
  localparam logic [7:0] OP_WIDE   = 8'h33;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } widthT;

  typedef struct packed {
    logic  load;
    logic  illegal;
    widthT width;
  } strobeT;

  function automatic logic [CNT_W:0] widthBits(input widthT w);
    return (CNT_W+1)'(MIN_W) << w;
  endfunction
endpackage

// File: rtl/mskshl_ctrl.sv
module mskshl_ctrl
  import mskshl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic [7:0] opByte,
  input  logic       wBit,
  input  logic [7:0] modrmByte,
  output strobeT     strb,
  output logic       validOut
);
  logic  opKnown;
  logic  regForm;
  widthT widthSel;
  logic  unusedModrm;

  assign unusedModrm = ^modrmByte[5:0];
  assign regForm     = (modrmByte[7:6] == 2'b11);

  always_comb begin
    opKnown  = 1'b1;
    widthSel = WID_8;
    unique case (opByte)
      OP_NARROW: widthSel = wBit ? WID_16 : WID_8;
      OP_WIDE:   widthSel = wBit ? WID_64 : WID_32;
      default:   opKnown  = 1'b0;
    endcase
  end

  always_comb begin
    strb.load    = validIn;
    strb.illegal = !(opKnown && regForm);
    strb.width   = widthSel;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

  // R8: valid output follows the strobe by exactly one clock
  p_valid_follow_r8: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);
  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);
endmodule

// File: rtl/mskshl_dpath.sv
module mskshl_dpath
  import mskshl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] srcMask,
  input  logic [CNT_W-1:0]  immCount,
  output logic [DATA_W-1:0] dstMask,
  output logic              illegalOut
);
  logic [DATA_W-1:0] stage [SHAMT_W+1];
  logic [DATA_W-1:0] maskTab [NUM_WID];
  logic [DATA_W-1:0] shiftRes;
  logic              overRange;

  assign stage[0] = srcMask;

  genvar gi;
  generate
    for (gi = 0; gi < SHAMT_W; gi++) begin : g_stage
      assign stage[gi+1] = immCount[gi] ? (stage[gi] << (1 << gi)) : stage[gi];
    end
    for (gi = 0; gi < NUM_WID; gi++) begin : g_mask
      localparam int BITS = MIN_W << gi;
      assign maskTab[gi] = {DATA_W{1'b1}} >> (DATA_W - BITS);
    end
  endgenerate

  assign overRange = {1'b0, immCount} >= widthBits(strb.width);
  assign shiftRes  = (overRange || strb.illegal) ? '0
                   : (stage[SHAMT_W] & maskTab[strb.width]);

  always_ff @(posedge clk) begin
    if (rst) begin
      dstMask    <= '0;
      illegalOut <= 1'b0;
    end else if (strb.load) begin
      dstMask    <= shiftRes;
      illegalOut <= strb.illegal;
    end
  end

  // R4: an out-of-range count leaves an all-zero result
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (strb.load && ({1'b0, immCount} >= widthBits(strb.width))) |=> (dstMask == '0));
  // R5: nothing above the byte width survives
  p_byte_upper_r5: assert property (@(posedge clk) disable iff (rst)
    (strb.load && strb.width == WID_8) |=> (dstMask[DATA_W-1:MIN_W] == '0));
  // R6 / R7: an illegal encoding always gives zero
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
    illegalOut |-> (dstMask == '0));
  // R8: the result holds between loads
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(dstMask));
endmodule

// File: rtl/mask_lshift_unit.sv
module mask_lshift_unit
  import mskshl_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        validIn,
  input  logic [63:0] srcMask,
  input  logic [7:0]  immCount,
  input  logic [7:0]  opByte,
  input  logic        wBit,
  input  logic [7:0]  modrmByte,
  output logic        validOut,
  output logic [63:0] dstMask,
  output logic        illegalOut
);
  strobeT strb;

  mskshl_ctrl u_ctrl (
    .clk(clk), .rst(rst), .validIn(validIn), .opByte(opByte), .wBit(wBit),
    .modrmByte(modrmByte), .strb(strb), .validOut(validOut)
  );

  mskshl_dpath u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .srcMask(srcMask), .immCount(immCount),
    .dstMask(dstMask), .illegalOut(illegalOut)
  );
endmodule

// File: tb/mask_lshift_unit_test.sv
module mask_lshift_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        validIn = 1'b0;
  logic [63:0] srcMask = '0;
  logic [7:0]  immCount = '0;
  logic [7:0]  opByte = 8'h32;
  logic        wBit = 1'b0;
  logic [7:0]  modrmByte = 8'hC0;
  logic        validOut;
  logic [63:0] dstMask;
  logic        illegalOut;

  int vecCount = 0;
  int failCount = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mask_lshift_unit uut (
    .clk(clk), .rst(rst), .validIn(validIn), .srcMask(srcMask),
    .immCount(immCount), .opByte(opByte), .wBit(wBit), .modrmByte(modrmByte),
    .validOut(validOut), .dstMask(dstMask), .illegalOut(illegalOut)
  );

  function automatic int refWidth(input logic [7:0] op, input logic w);
    if (op == 8'h32) return w ? 16 : 8;
    if (op == 8'h33) return w ? 64 : 32;
    return 0;
  endfunction

  function automatic logic [63:0] refShift(input logic [63:0] s, input logic [7:0] c,
                                           input logic [7:0] op, input logic w,
                                           input logic [7:0] m);
    int wd;
    logic [63:0] r;
    wd = refWidth(op, w);
    if (wd == 0 || m[7:6] != 2'b11 || int'(c) >= wd) return '0;
    r = '0;
    for (int i = 0; i < wd; i++)
      if (i >= int'(c)) r[i] = s[i - int'(c)];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic applyOne(input string req, input logic [63:0] s, input logic [7:0] c,
                          input logic [7:0] op, input logic w, input logic [7:0] m);
    logic expIll;
    @(negedge clk);
    srcMask = s; immCount = c; opByte = op; wBit = w; modrmByte = m; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    expIll = (refWidth(op, w) == 0) || (m[7:6] != 2'b11);
    check(req, dstMask, refShift(s, c, op, w, m));
    check({req, " illegal"}, {63'b0, illegalOut}, {63'b0, expIll});
    check("R8 valid", {63'b0, validOut}, 64'd1);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 dst", dstMask, '0);
    check("R9 valid", {63'b0, validOut}, '0);
    check("R9 illegal", {63'b0, illegalOut}, '0);
    rst = 1'b0;
  endtask

  task automatic testWidthSweep();
    logic [63:0] pats [2];
    pats[0] = '1;
    pats[1] = 64'h9000_4102_0080_2A05;
    for (int p = 0; p < 2; p++)
      for (int wsel = 0; wsel < 4; wsel++)
        for (int c = 0; c < 256; c++)
          applyOne(wsel < 2 ? "R1 R3 R4 R5" : "R2 R3 R4 R5", pats[p], 8'(c),
                   wsel < 2 ? 8'h32 : 8'h33, wsel[0], 8'hC5);
  endtask

  task automatic testBoundaries();
    applyOne("R4 byte c7", 64'hFFFF_FFFF_FFFF_FF01, 8'd7, 8'h32, 1'b0, 8'hC0);
    check("R4 byte c7 value", dstMask, 64'h80);
    applyOne("R4 byte c8", 64'hFF, 8'd8, 8'h32, 1'b0, 8'hC0);
    applyOne("R4 quad c63", 64'h1, 8'd63, 8'h33, 1'b1, 8'hFF);
    check("R3 quad c63 value", dstMask, 64'h8000_0000_0000_0000);
    applyOne("R4 quad c64", 64'h1, 8'd64, 8'h33, 1'b1, 8'hFF);
    applyOne("R4 quad c255", '1, 8'd255, 8'h33, 1'b1, 8'hFF);
    applyOne("R5 dword upper", '1, 8'd0, 8'h33, 1'b0, 8'hC0);
    check("R5 dword value", dstMask, 64'hFFFF_FFFF);
  endtask

  task automatic testIllegalModrm();
    for (int top = 0; top < 3; top++) begin
      applyOne("R6 modrm", '1, 8'd1, 8'h33, 1'b1, {2'(top), 6'h05});
      check("R6 flag", {63'b0, illegalOut}, 64'd1);
    end
  endtask

  task automatic testBadOpcode();
    applyOne("R7 op31", '1, 8'd0, 8'h31, 1'b1, 8'hC0);
    applyOne("R7 op34", '1, 8'd2, 8'h34, 1'b0, 8'hC0);
    check("R7 flag", {63'b0, illegalOut}, 64'd1);
    applyOne("R7 legal after", 64'h3, 8'd1, 8'h32, 1'b1, 8'hC0);
    check("R7 flag clear", {63'b0, illegalOut}, 64'd0);
  endtask

  task automatic testHold();
    applyOne("R8 load", 64'hA5, 8'd4, 8'h32, 1'b1, 8'hC0);
    @(negedge clk);
    srcMask = '1; immCount = 8'd0; opByte = 8'h34;
    repeat (3) @(negedge clk);
    check("R8 hold dst", dstMask, 64'hA50);
    check("R8 hold illegal", {63'b0, illegalOut}, 64'd0);
    check("R8 idle valid", {63'b0, validOut}, 64'd0);
  endtask

  initial begin
    testReset();
    testWidthSweep();
    testBoundaries();
    testIllegalModrm();
    testBadOpcode();
    testHold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        failCount++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule